// File: doc/BRIEF.md
# Sleep Wake-Up Sequencer

This block decides when a small processor core stops its instruction clock on a sleep instruction, and how it starts again when the external interrupt pin fires. It holds the interrupt flag, tracks the four oscillator phases of each instruction cycle, and waits for the oscillator to settle when a crystal is in use. Once the core runs again it tells the fetch and execute pipeline whether to take the interrupt vector or to carry on with the code that follows the sleep instruction.

Each instruction cycle lasts four oscillator clocks, and the phase counter sits at 0 to 3 within it. A sleep request is only acted on in the last phase of a normal running cycle. On wake, the first instruction cycle always completes the instruction that was fetched before sleep. If the global interrupt enable was set at the moment of wake, a dummy cycle follows, during which the pipeline loads the program counter with the vector address. If the enable was clear, execution simply goes on in line.

Top module: `sleep_wake_seq`

## Requirements
- R1: While reset is applied, core_run is 1, asleep, int_flag, dummy_cyc and vec_load are 0, and q_phase is 0.
- R2: While core_run is 1 outside wake transitions, q_phase steps 0,1,2,3,0 on each clock and cyc_last is 1 exactly when q_phase is 3.
- R3: When slp_exec is 1 in the last phase of a running cycle and no interrupt is pending, core_run is 0 and asleep is 1 from the next clock.
- R4: A pulse on ext_int_edge sets int_flag on the next clock in any state. flag_clr clears it, and a set in the same clock wins over a clear.
- R5: If int_flag is already 1, or ext_int_edge is 1, when the sleep request is taken, sleep is not entered and core_run stays 1.
- R6: With osc_mode 00, 01 or 10 (crystal types), core_run returns to 1 exactly 1026 clocks after the clock in which ext_int_edge was 1 during sleep (one clock to set the flag, one to leave sleep, 1024 start-up periods).
- R7: With osc_mode 11 (external clock or RC), the start-up wait is skipped and core_run returns 2 clocks after the wake edge.
- R8: The first instruction cycle after wake is four clocks with dummy_cyc and vec_load both 0.
- R9: If gie was 1 at wake, the second cycle after wake is a dummy cycle: dummy_cyc is 1 for four clocks, vec_load is 1 only in its first clock, and vec_addr is 0x0004.
- R10: If gie was 0 at wake, no dummy cycle and no vec_load follow, and the core runs on in line.
- R11: The start-up wait restarts from zero on every sleep entry, so a second crystal-mode wake again takes 1026 clocks.
- R12: gie is sampled when the core leaves sleep. A change of gie after that point does not alter the choice made in R9 or R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_exec | input | 1 | Sleep instruction is executing in this cycle |
| ext_int_edge | input | 1 | Detected edge on the external interrupt pin (one clock) |
| flag_clr | input | 1 | Clear request for the interrupt flag |
| gie | input | 1 | Global interrupt enable |
| osc_mode | input | 2 | Oscillator type: 00/01/10 crystal, 11 external clock or RC |
| core_run | output | 1 | Instruction clock enable for the core |
| asleep | output | 1 | Core is in sleep or waiting for oscillator start-up |
| q_phase | output | 2 | Phase within the current instruction cycle |
| cyc_last | output | 1 | Last phase of a running instruction cycle |
| int_flag | output | 1 | External interrupt flag |
| dummy_cyc | output | 1 | Pipeline must execute a dummy cycle |
| vec_load | output | 1 | Load the program counter with vec_addr |
| vec_addr | output | PC_W | Interrupt vector address |

## Verification
The bench measures the wake latency clock by clock in every oscillator mode: a design that skipped the start-up wait for a crystal, or applied it to an external clock, would return core_run early or late by 1024 clocks. A second crystal wake catches a start-up counter that is not cleared on sleep entry, which would make the second wake come back almost at once. Sleep requests with a flag already set, or with an edge in the same clock, catch a core that would go to sleep and lose the interrupt. Changing gie after wake catches a design that reads the live enable instead of the value at wake, which would add or drop the dummy cycle and vector load.

// File: rtl/sws_pkg.sv
package sws_pkg;

  typedef enum logic [2:0] {
    ST_RUN    = 3'd0,
    ST_SLEEP  = 3'd1,
    ST_OSTW   = 3'd2,
    ST_RESUME = 3'd3,
    ST_DUMMY  = 3'd4
  } sws_state_e;

  localparam logic [1:0] OSC_DIRECT = 2'b11;

  function automatic logic needs_startup(input logic [1:0] mode);
    return (mode != OSC_DIRECT);
  endfunction

endpackage

// File: rtl/sws_rst_sync.sv
module sws_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sws_phase_ctr.sv
module sws_phase_ctr #(
  parameter int PHASES = 4,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [PW-1:0] phase,
  output logic          last
);
  logic [PW-1:0] phase_d;

  always_comb begin
    if (!run)                                    phase_d = '0;
    else if (phase == PW'(PHASES - 1))           phase_d = '0;
    else                                         phase_d = phase + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase_d;
  end

  assign last = run && (phase == PW'(PHASES - 1));
endmodule

// File: rtl/sws_ost_ctr.sv
module sws_ost_ctr #(
  parameter int LIMIT = 1024,
  localparam int CW = $clog2(LIMIT)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_end;

  assign at_end = (cnt_q == CW'(LIMIT - 1));
  assign cnt_en = clr || (en && !at_end);

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = en && at_end;
endmodule

// File: rtl/sws_int_flag.sv
module sws_int_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d, flag_en;

  assign flag_en = set || clr;
  assign flag_d  = set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (flag_en) flag <= flag_d;
  end
endmodule

// File: rtl/sleep_wake_seq.sv
module sleep_wake_seq
  import sws_pkg::*;
#(
  parameter int          PC_W       = 13,
  parameter int          OST_CYCLES = 1024,
  parameter logic [12:0] VECTOR     = 13'h0004
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slp_exec,
  input  logic            ext_int_edge,
  input  logic            flag_clr,
  input  logic            gie,
  input  logic [1:0]      osc_mode,
  output logic            core_run,
  output logic            asleep,
  output logic [1:0]      q_phase,
  output logic            cyc_last,
  output logic            int_flag,
  output logic            dummy_cyc,
  output logic            vec_load,
  output logic [PC_W-1:0] vec_addr
);
  logic       rst_sync_n;
  sws_state_e state_q, state_d;
  logic       gie_lat_q, gie_lat_d, gie_lat_en;
  logic       ost_done;
  logic       sleep_take;
  logic       wake_now;

  sws_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sws_int_flag u_flag (
    .clk(clk), .rst_n(rst_sync_n), .set(ext_int_edge), .clr(flag_clr),
    .flag(int_flag)
  );

  sws_phase_ctr #(.PHASES(4)) u_phase (
    .clk(clk), .rst_n(rst_sync_n), .run(core_run),
    .phase(q_phase), .last(cyc_last)
  );

  sws_ost_ctr #(.LIMIT(OST_CYCLES)) u_ost (
    .clk(clk), .rst_n(rst_sync_n),
    .clr(state_q == ST_SLEEP), .en(state_q == ST_OSTW),
    .done(ost_done)
  );

  assign sleep_take = (state_q == ST_RUN) && cyc_last && slp_exec
                      && !int_flag && !ext_int_edge;
  assign wake_now   = (state_q == ST_SLEEP) && int_flag;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:    if (sleep_take) state_d = ST_SLEEP;
      ST_SLEEP:  if (wake_now)
                   state_d = needs_startup(osc_mode) ? ST_OSTW : ST_RESUME;
      ST_OSTW:   if (ost_done) state_d = ST_RESUME;
      ST_RESUME: if (cyc_last) state_d = gie_lat_q ? ST_DUMMY : ST_RUN;
      ST_DUMMY:  if (cyc_last) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  assign gie_lat_en = wake_now;
  assign gie_lat_d  = gie;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_RUN;
      gie_lat_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (gie_lat_en) gie_lat_q <= gie_lat_d;
    end
  end

  assign core_run  = (state_q == ST_RUN) || (state_q == ST_RESUME)
                     || (state_q == ST_DUMMY);
  assign asleep    = (state_q == ST_SLEEP) || (state_q == ST_OSTW);
  assign dummy_cyc = (state_q == ST_DUMMY);
  assign vec_load  = (state_q == ST_DUMMY) && (q_phase == 2'd0);
  assign vec_addr  = PC_W'(VECTOR);
endmodule

// File: rtl/sleep_wake_seq_chk.sv
module sleep_wake_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slp_exec,
  input logic       ext_int_edge,
  input logic       core_run,
  input logic       asleep,
  input logic [1:0] q_phase,
  input logic       cyc_last,
  input logic       int_flag,
  input logic       dummy_cyc,
  input logic       vec_load
);
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_run && q_phase != 2'd3) |=> (q_phase == $past(q_phase) + 2'd1));

  assert_sleep_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_last && slp_exec && !int_flag && !ext_int_edge && !dummy_cyc
     && !asleep && $past(core_run) && !$past(asleep)) |=> (asleep && !core_run));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_int_edge |=> int_flag);

  assert_no_sleep_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_last && slp_exec && (int_flag || ext_int_edge)) |=> core_run);

  assert_vec_in_dummy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_load |-> (dummy_cyc && core_run));

  assert_dummy_starts_vec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dummy_cyc) |-> vec_load);

  assert_run_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_run && asleep));
endmodule

bind sleep_wake_seq sleep_wake_seq_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .slp_exec(slp_exec), .ext_int_edge(ext_int_edge),
  .core_run(core_run), .asleep(asleep), .q_phase(q_phase), .cyc_last(cyc_last),
  .int_flag(int_flag), .dummy_cyc(dummy_cyc), .vec_load(vec_load)
);

// File: tb/sleep_wake_seq_tb.sv
`timescale 1ns/1ps
module sleep_wake_seq_tb;
  localparam int PC_W = 13;
  localparam int OST  = 1024;

  logic clk = 1'b0;
  logic rst_n, slp_exec, ext_int_edge, flag_clr, gie;
  logic [1:0] osc_mode;
  logic core_run, asleep, cyc_last, int_flag, dummy_cyc, vec_load;
  logic [1:0] q_phase;
  logic [PC_W-1:0] vec_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sleep_wake_seq #(.PC_W(PC_W), .OST_CYCLES(OST)) u_dut (
    .clk(clk), .rst_n(rst_n), .slp_exec(slp_exec), .ext_int_edge(ext_int_edge),
    .flag_clr(flag_clr), .gie(gie), .osc_mode(osc_mode),
    .core_run(core_run), .asleep(asleep), .q_phase(q_phase), .cyc_last(cyc_last),
    .int_flag(int_flag), .dummy_cyc(dummy_cyc), .vec_load(vec_load),
    .vec_addr(vec_addr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc_end();
    int guard = 0;
    @(negedge clk);
    while (!cyc_last && guard < 16) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 core_run", core_run, 1);
    chk("R1 asleep", asleep, 0);
    chk("R1 int_flag", int_flag, 0);
    chk("R1 dummy/vec", {dummy_cyc, vec_load}, 0);
    chk("R1 q_phase", q_phase, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_phase();
    logic [1:0] prev;
    @(negedge clk);
    prev = q_phase;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R2 phase step", q_phase, (prev + 2'd1) & 2'd3);
      chk("R2 cyc_last", cyc_last, (q_phase == 2'd3) ? 1 : 0);
      prev = q_phase;
    end
  endtask

  task automatic t_flag();
    ext_int_edge = 1'b1;
    @(negedge clk);
    ext_int_edge = 1'b0;
    chk("R4 set", int_flag, 1);
    ext_int_edge = 1'b1;
    flag_clr = 1'b1;
    @(negedge clk);
    ext_int_edge = 1'b0;
    flag_clr = 1'b0;
    chk("R4 set wins", int_flag, 1);
    clear_flag();
    chk("R4 clear", int_flag, 0);
  endtask

  task automatic t_blocked();
    ext_int_edge = 1'b1;
    @(negedge clk);
    ext_int_edge = 1'b0;
    wait_cyc_end();
    slp_exec = 1'b1;
    @(negedge clk);
    slp_exec = 1'b0;
    chk("R5 pending flag keeps run", core_run, 1);
    clear_flag();
    wait_cyc_end();
    slp_exec = 1'b1;
    ext_int_edge = 1'b1;
    @(negedge clk);
    slp_exec = 1'b0;
    ext_int_edge = 1'b0;
    chk("R5 same-clock edge keeps run", core_run, 1);
    chk("R5 asleep", asleep, 0);
    clear_flag();
  endtask

  task automatic t_wake(input logic [1:0] mode, input logic g,
                        input bit flip_gie, input string req);
    int n;
    int exp_lat;
    logic eff_g;
    gie = g;
    osc_mode = mode;
    wait_cyc_end();
    slp_exec = 1'b1;
    @(negedge clk);
    slp_exec = 1'b0;
    chk("R3 core stops", core_run, 0);
    chk("R3 asleep", asleep, 1);
    repeat (5) @(negedge clk);
    chk("R3 stays asleep", asleep, 1);
    ext_int_edge = 1'b1;
    n = 0;
    @(negedge clk);
    ext_int_edge = 1'b0;
    n = 1;
    while (!core_run && n < 5000) begin
      @(negedge clk);
      n++;
      if (flip_gie && n == 3) gie = ~g;
    end
    exp_lat = (mode != 2'b11) ? OST + 2 : 2;
    chk(req, n, exp_lat);
    eff_g = g;
    for (int i = 0; i < 4; i++) begin
      chk("R8 resume cycle no dummy", {dummy_cyc, vec_load}, 0);
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      if (eff_g) begin
        chk("R9 dummy_cyc", dummy_cyc, 1);
        chk("R9 vec_load", vec_load, (i == 0) ? 1 : 0);
        if (i == 0) chk("R9 vec_addr", vec_addr, 4);
      end else begin
        chk("R10 inline no dummy", {dummy_cyc, vec_load}, 0);
        chk("R10 running", core_run, 1);
      end
      @(negedge clk);
    end
    if (flip_gie) chk("R12 gie sampled at wake", {1'b0, eff_g}, {1'b0, g});
    chk("R10 back to run", core_run, 1);
    clear_flag();
    gie = 1'b0;
  endtask

  initial begin
    slp_exec = 1'b0; ext_int_edge = 1'b0; flag_clr = 1'b0;
    gie = 1'b0; osc_mode = 2'b01;
    t_reset();
    t_phase();
    t_flag();
    t_blocked();
    t_wake(2'b01, 1'b1, 1'b0, "R6 crystal XT latency");
    t_wake(2'b01, 1'b0, 1'b0, "R11 second crystal wake latency");
    t_wake(2'b00, 1'b1, 1'b1, "R6 crystal LP latency R12");
    t_wake(2'b10, 1'b0, 1'b1, "R6 crystal HS latency R12");
    t_wake(2'b11, 1'b1, 1'b0, "R7 direct clock latency");
    t_wake(2'b11, 1'b0, 1'b0, "R7 direct clock inline");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule